// File: doc/BRIEF.md
# Debug Halt and Cause Controller

This block decides when a processor core must be frozen for a debugger and keeps a record of what caused the freeze. The core reports exceptions as a one-hot event vector of thirteen classes, with bit k standing for class k. A stop-enable register selects which classes halt the core. A cause register keeps, for each class that was seen, whether it led to a halt. A debugger-disable bit overrides every request to halt.

A host port writes and reads a small register set. Through it the host sets or clears the halt directly, holds the core in reset, and loads one instruction to inject. An injected instruction goes to the fetch stage over a valid/ready pair once the core is halted and out of reset. When the host releases its reset-hold bit, the block sends the core a one-cycle reset pulse.

Host map (3-bit address): 0 control (bit 0 halt, bit 1 reset hold, bit 2 debugger disable), 1 stop-enable, 2 cause, 3 injection (write only). Host accesses complete in the same cycle: read data and the error flag are combinational. The injection stream follows these rules. `inj_valid` is high while an instruction is pending, the core is halted and reset hold is clear. The fetch stage takes the instruction on any cycle where `inj_valid` and `inj_ready` are both high. While it holds `inj_ready` low, the instruction stays pending and its data stays fixed. If the halt drops or reset hold rises, `inj_valid` is withdrawn. A fresh host write replaces a pending instruction.

Top module: `dbg_halt_unit`

## Requirements
- R1: After synchronous reset, halt, cause, stop-enable, the reset pulse and `inj_valid` are all 0.
- R2: An event on bit k with stop-enable bit k set and the disable bit clear sets `halt_o` and cause bit k on the next clock.
- R3: An event on bit k with stop-enable bit k clear writes 0 into cause bit k and leaves `halt_o` unchanged.
- R4: While the debugger-disable bit (control bit 2) is 1, `halt_o` is 0. This holds both for a control write that asks for a halt and for an enabled event. The event still writes its cause bit.
- R5: A control write sets `halt_o` to control bit 0 on the next clock. A control read returns {disable, hold, halt} in bits 2..0.
- R6: Cause bits hold their value until the host writes address 2, which replaces all of them.
- R7: A write to address 3 while the core is halted and out of reset raises `inj_valid` on the next clock, with the written word on `inj_insn`.
- R8: A pending instruction waits with `inj_valid` low while the core is not halted. `inj_valid` rises in the same cycle that `halt_o` rises.
- R9: While `inj_ready` is low, `inj_valid` and `inj_insn` stay unchanged. A cycle with both `inj_valid` and `inj_ready` high accepts the instruction, and `inj_valid` is low on the next cycle.
- R10: While control bit 1 (reset hold) is 1, `inj_valid` stays low.
- R11: A control write that takes bit 1 from 1 to 0 gives exactly one cycle of `core_rst_o` on the next clock. Taking it from 0 to 1 gives no pulse.
- R12: A read of address 3, or any access to addresses 4 to 7, sets `host_err`. The error read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_evt | input | NUM_EXC | One-hot exception events from the core |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational) |
| host_err | output | 1 | Access error for the current host access |
| halt_o | output | 1 | Core halt request |
| reason_o | output | NUM_EXC | Cause register |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| inj_valid | output | 1 | Injected instruction offered to fetch |
| inj_ready | input | 1 | Fetch stage accepts the offered instruction |
| inj_insn | output | DATA_W | Injected instruction word |

## Verification
The bench targets these corner cases:
- An instruction written while the core runs must not leak out early. It must appear in the very cycle the halt rises; a design that waits for a later edge adds a cycle of lag.
- A stalled fetch stage must see a steady word.
- Reset hold must mask the injection stream, and its release must produce exactly one reset pulse. A design that pulses on the wrong edge fires when reset hold is applied.
- The disable bit must cancel a halt while still letting the cause bit load.
- An unenabled event must clear its cause bit without touching the others.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  localparam int HOST_AW = 3;

  typedef enum logic [HOST_AW-1:0] {
    REG_CTRL   = 3'd0,
    REG_STOPEN = 3'd1,
    REG_CAUSE  = 3'd2,
    REG_INJECT = 3'd3
  } host_reg_e;

  // Exception class per event bit index
  typedef enum int {
    EXC_RESET, EXC_BUSERR, EXC_ALIGN, EXC_ILLEGAL, EXC_RANGE, EXC_SYSCALL,
    EXC_BREAK, EXC_IPAGE, EXC_DPAGE, EXC_ITLB, EXC_DTLB, EXC_IRQ_LO,
    EXC_IRQ_HI, EXC_COUNT
  } exc_class_e;

  typedef struct packed {
    logic dis;
    logic hold;
    logic halt;
  } ctrl_t;

endpackage

// File: rtl/dbg_reason_bank.sv
module dbg_reason_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] exc_evt,
  input  logic         en_wr,
  input  logic         cause_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] stop_en,
  output logic [N-1:0] cause,
  output logic         halt_req
);
  logic [N-1:0] cause_base;

  assign halt_req   = |(exc_evt & stop_en);
  assign cause_base = cause_wr ? wdata : cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_en <= '0;
      cause   <= '0;
    end else begin
      if (en_wr) stop_en <= wdata;
      cause <= (cause_base & ~exc_evt) | (exc_evt & stop_en);
    end
  end

  assert_unarmed_clears_cause_R3: assert property (@(posedge clk) disable iff (rst)
    ((|(exc_evt & ~stop_en)) && !cause_wr) |=> ((cause & $past(exc_evt & ~stop_en)) == '0));

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ctrl_wr,
  input  ctrl_t ctrl_wdata,
  input  logic  halt_req,
  output logic  halt,
  output logic  hold,
  output logic  dis,
  output logic  core_rst
);
  logic dis_n, hold_n, halt_n;

  always_comb begin
    dis_n  = ctrl_wr ? ctrl_wdata.dis  : dis;
    hold_n = ctrl_wr ? ctrl_wdata.hold : hold;
    halt_n = ((ctrl_wr ? ctrl_wdata.halt : halt) | halt_req) & ~dis_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt     <= 1'b0;
      hold     <= 1'b0;
      dis      <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      halt     <= halt_n;
      hold     <= hold_n;
      dis      <= dis_n;
      core_rst <= hold & ~hold_n;
    end
  end

  assert_armed_event_halts_R2: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !dis && !ctrl_wr) |=> halt);

  assert_disable_cancels_halt_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_wdata.dis) |=> !halt);

  assert_single_reset_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> !core_rst);

endmodule

// File: rtl/dbg_inject_slot.sv
module dbg_inject_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inj_wr,
  input  logic [W-1:0] wdata,
  input  logic         halted,
  input  logic         hold,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] insn
);
  logic pend;

  assign valid = pend & halted & ~hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      insn <= '0;
    end else if (inj_wr) begin
      pend <= 1'b1;
      insn <= wdata;
    end else if (valid && ready) begin
      pend <= 1'b0;
    end
  end

  assert_stall_keeps_word_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !inj_wr) |=> (pend && $stable(insn)));

  assert_accept_retires_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && !inj_wr) |=> !valid);

  assert_hold_masks_stream_R10: assert property (@(posedge clk) disable iff (rst)
    hold |-> !valid);

endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
  import dbg_halt_pkg::*;
#(
  parameter int NUM_EXC = 13,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] exc_evt,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_err,
  output logic               halt_o,
  output logic [NUM_EXC-1:0] reason_o,
  output logic               core_rst_o,
  output logic               inj_valid,
  input  logic               inj_ready,
  output logic [DATA_W-1:0]  inj_insn
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic               hit_ctrl, hit_stopen, hit_cause, hit_inject, hit_none;
  logic [NUM_EXC-1:0] stop_en;
  logic               halt_req, hold, dis;
  ctrl_t              ctrl_wdata;

  assign hit_ctrl   = host_addr == REG_CTRL;
  assign hit_stopen = host_addr == REG_STOPEN;
  assign hit_cause  = host_addr == REG_CAUSE;
  assign hit_inject = host_addr == REG_INJECT;
  assign hit_none   = !(hit_ctrl || hit_stopen || hit_cause || hit_inject);
  assign ctrl_wdata = ctrl_t'(host_wdata[CTRL_W-1:0]);

  dbg_reason_bank #(.N(NUM_EXC)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .exc_evt  (exc_evt),
    .en_wr    (host_wr && hit_stopen),
    .cause_wr (host_wr && hit_cause),
    .wdata    (host_wdata[NUM_EXC-1:0]),
    .stop_en  (stop_en),
    .cause    (reason_o),
    .halt_req (halt_req)
  );

  dbg_halt_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (host_wr && hit_ctrl),
    .ctrl_wdata (ctrl_wdata),
    .halt_req   (halt_req),
    .halt       (halt_o),
    .hold       (hold),
    .dis        (dis),
    .core_rst   (core_rst_o)
  );

  dbg_inject_slot #(.W(DATA_W)) u_inj (
    .clk    (clk),
    .rst    (rst),
    .inj_wr (host_wr && hit_inject),
    .wdata  (host_wdata),
    .halted (halt_o),
    .hold   (hold),
    .ready  (inj_ready),
    .valid  (inj_valid),
    .insn   (inj_insn)
  );

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (hit_ctrl)   host_rdata[CTRL_W-1:0]  = {dis, hold, halt_o};
      if (hit_stopen) host_rdata[NUM_EXC-1:0] = stop_en;
      if (hit_cause)  host_rdata[NUM_EXC-1:0] = reason_o;
    end
    host_err = (host_rd && (hit_inject || hit_none)) || (host_wr && hit_none);
  end

endmodule

// File: tb/tb_dbg_halt_unit.sv
module tb_dbg_halt_unit;
  localparam int N = 13;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] exc_evt;
  logic         host_wr, host_rd;
  logic [2:0]   host_addr;
  logic [W-1:0] host_wdata, host_rdata;
  logic         host_err, halt_o, core_rst_o, inj_valid, inj_ready;
  logic [N-1:0] reason_o;
  logic [W-1:0] inj_insn;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  dbg_halt_unit #(.NUM_EXC(N), .DATA_W(W)) dut (
    .clk(clk), .rst(rst), .exc_evt(exc_evt), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_err(host_err), .halt_o(halt_o), .reason_o(reason_o), .core_rst_o(core_rst_o),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_insn(inj_insn)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; #1;
  endtask

  task automatic host_read(logic [2:0] a, output logic [W-1:0] d, output logic e);
    @(negedge clk); host_rd = 1'b1; host_addr = a; #1;
    d = host_rdata; e = host_err; host_rd = 1'b0;
  endtask

  task automatic pulse_exc(int k);
    @(negedge clk); exc_evt = N'(1) << k;
    @(negedge clk); exc_evt = '0; #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_ready(logic v);
    @(negedge clk); inj_ready = v; #1;
  endtask

  // Monitor: every accepted injection is popped from the scoreboard
  always @(negedge clk) begin
    #1;
    if (!rst && inj_valid && inj_ready) begin
      if (exp_q.size() == 0) begin
        vec_cnt++; bad_cnt++;
        $display("FAIL R9: actual issue %h expected none", inj_insn);
      end else begin
        chk("R7 issued word", inj_insn, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vec_cnt++; bad_cnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    logic er;
    rst = 1'b1; exc_evt = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = '0; host_wdata = '0; inj_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; #1;

    // R1 reset state
    chk("R1 halt", W'(halt_o), 0);
    chk("R1 cause", W'(reason_o), 0);
    chk("R1 valid", W'(inj_valid), 0);
    chk("R1 pulse", W'(core_rst_o), 0);
    host_read(3'd1, rd, er);
    chk("R1 stop-enable", rd, 0);

    // R3 / R2 event handling
    host_write(3'd1, 32'h0005);
    pulse_exc(1);
    chk("R3 no halt", W'(halt_o), 0);
    chk("R3 cause", W'(reason_o), 0);
    pulse_exc(2);
    chk("R2 halt", W'(halt_o), 1);
    chk("R2 cause", W'(reason_o), 32'h4);

    // R6 cause hold and replace
    idle(3);
    chk("R6 hold", W'(reason_o), 32'h4);
    host_write(3'd2, 32'h000A);
    chk("R6 replace", W'(reason_o), 32'hA);
    pulse_exc(1);
    chk("R3 clears bit", W'(reason_o), 32'h8);
    chk("R3 halt kept", W'(halt_o), 1);
    host_write(3'd2, 32'h0);
    chk("R6 clear", W'(reason_o), 0);

    // R5 control writes
    host_write(3'd0, 32'h0);
    chk("R5 clear halt", W'(halt_o), 0);
    host_write(3'd0, 32'h1);
    chk("R5 set halt", W'(halt_o), 1);
    host_read(3'd0, rd, er);
    chk("R5 readback", rd, 32'h1);

    // R7 / R9 injection while halted, with back-pressure
    exp_q.push_back(32'hA5A5_0001);
    host_write(3'd3, 32'hA5A5_0001);
    chk("R7 valid", W'(inj_valid), 1);
    chk("R7 word", inj_insn, 32'hA5A5_0001);
    idle(3);
    chk("R9 valid held", W'(inj_valid), 1);
    chk("R9 word held", inj_insn, 32'hA5A5_0001);
    set_ready(1'b1);
    idle(1);
    chk("R9 retired", W'(inj_valid), 0);

    // R8 pending while running, issued at halt rise
    host_write(3'd0, 32'h0);
    exp_q.push_back(32'h1234_5678);
    host_write(3'd3, 32'h1234_5678);
    idle(3);
    chk("R8 waits", W'(inj_valid), 0);
    pulse_exc(0);
    chk("R8 halt", W'(halt_o), 1);
    chk("R8 valid with halt", W'(inj_valid), 1);
    idle(1);
    chk("R8 retired", W'(inj_valid), 0);

    // R10 / R11 reset hold
    host_write(3'd0, 32'h3);
    chk("R11 no pulse on raise", W'(core_rst_o), 0);
    exp_q.push_back(32'hDEAD_BEEF);
    host_write(3'd3, 32'hDEAD_BEEF);
    idle(2);
    chk("R10 masked", W'(inj_valid), 0);
    host_write(3'd0, 32'h1);
    chk("R11 pulse", W'(core_rst_o), 1);
    chk("R10 released", W'(inj_valid), 1);
    idle(1);
    chk("R11 one cycle", W'(core_rst_o), 0);

    // R4 disable override
    host_write(3'd0, 32'h5);
    chk("R4 halt cancelled", W'(halt_o), 0);
    pulse_exc(2);
    chk("R4 event no halt", W'(halt_o), 0);
    chk("R4 cause loads", W'(reason_o), 32'h5);
    host_read(3'd0, rd, er);
    chk("R4 readback", rd, 32'h4);
    host_write(3'd0, 32'h0);

    // R12 error accesses
    host_read(3'd3, rd, er);
    chk("R12 inject err", W'(er), 1);
    chk("R12 inject data", rd, 0);
    host_read(3'd6, rd, er);
    chk("R12 hole err", W'(er), 1);
    host_read(3'd1, rd, er);
    chk("R12 legal no err", W'(er), 0);
    chk("R12 legal data", rd, 32'h5);

    idle(2);
    chk("R7 all issued", W'(exp_q.size()), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule